// File: doc/BRIEF.md
# Cache-Allocate Store Undo Log

This block sits beside a load/store unit and keeps an ordered record of cache-allocating stores. Each time such a store targets a cacheable address, the block saves the store address together with the word that memory held before the store. The record lets a later operand-cache line invalidate undo a store whose data was never meant to reach memory. An example is a cache flush sequence that allocates lines with dummy data and then invalidates them.

When an invalidate names a 32-byte line that matches one or more saved entries, the block takes the oldest matching entry. It sends that entry's saved word back to the saved address through a valid/ready write port and removes only that entry. Any instruction that is neither an allocating store nor an invalidate discards the whole record. A pending output stays high while the record holds anything, so that surrounding logic can carry a "flush still possible" condition across instruction-block boundaries.

Top module: `alloc_undo_log`

## Requirements
- R1: A synchronous active-high reset empties the log, clears the overflow flag and drops any restore request. After reset, pending, overflow, busy and the write request are all low.
- R2: The instruction class comes from the 16-bit opcode ANDed with 0xF0FF. The result 0x00C3 is an allocating store and 0x0093 is an invalidate. Any other result is an unrelated instruction. Opcode bits [11:8] therefore do not affect the class.
- R3: An allocating store with the cacheable input high appends its address and its old data word at the tail of the log, so entries stay in program order.
- R4: An allocating store with the cacheable input low leaves the log unchanged.
- R5: An invalidate matches an entry when address bits [31:5] agree. On a match, the oldest matching entry's saved word is presented on the write port at its saved address in the cycle after the invalidate. Only that entry is removed.
- R6: An invalidate that matches no entry raises no write request, leaves the log unchanged and does not make the block busy.
- R7: An accepted unrelated instruction empties the whole log. The overflow flag is not affected.
- R8: The log holds DEPTH entries (8 by default). A cacheable allocating store that arrives while the log is full is not recorded and sets a sticky overflow flag that only reset clears.
- R9: The write request stays high with stable address and data until the write is accepted with ready. While it is high, busy is high and every instruction strobe is ignored.
- R10: The pending output is high exactly when the log holds at least one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr_op | input | 16 | Instruction opcode |
| instr_addr | input | 32 | Operand address of the store or invalidate |
| instr_old | input | 32 | Memory word at the address before the store |
| instr_cacheable | input | 1 | Operand address is cacheable |
| busy | output | 1 | Restore in progress; instruction strobes are ignored |
| wr_valid | output | 1 | Restore write request |
| wr_ready | input | 1 | Memory accepts the restore write |
| wr_addr | output | 32 | Restore write address |
| wr_data | output | 32 | Restore write data |
| pending | output | 1 | Log is not empty |
| overflow | output | 1 | Sticky: a cacheable store was dropped because the log was full |

## Verification
The hardest case to reach is an instruction strobe that arrives while a restore write is stalled. If that strobe leaked through, it would corrupt the log without changing anything visible at that moment. The bench records two stores to the same line and invalidates that line while holding ready low. During the stall it drives an unrelated instruction, which would empty the log if it were accepted. After the write is accepted, a second invalidate must still restore the younger store's saved word. A full log is driven past its limit, and the dropped store is then probed with an invalidate of its own line, which must produce no write.

// File: rtl/aul_pkg.sv
package aul_pkg;

    typedef enum logic [1:0] {
        CLS_OTHER = 2'd0,
        CLS_ALLOC = 2'd1,
        CLS_INVAL = 2'd2
    } instr_cls_e;

    localparam logic [15:0] OP_MASK  = 16'hF0FF;
    localparam logic [15:0] OP_ALLOC = 16'h00C3;
    localparam logic [15:0] OP_INVAL = 16'h0093;

endpackage

// File: rtl/aul_decode.sv
module aul_decode
    import aul_pkg::*;
(
    input  logic [15:0] op,
    output instr_cls_e  cls
);
    logic [15:0] masked;

    always_comb begin
        masked = op & OP_MASK;
        if (masked == OP_ALLOC)
            cls = CLS_ALLOC;
        else if (masked == OP_INVAL)
            cls = CLS_INVAL;
        else
            cls = CLS_OTHER;
    end
endmodule

// File: rtl/aul_match.sv
module aul_match #(
    parameter int DEPTH     = 8,
    parameter int AW        = 32,
    parameter int LINE_BITS = 5,
    parameter int CW        = $clog2(DEPTH + 1),
    parameter int IW        = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][AW-1:0] ent_addr,
    input  logic [CW-1:0]            ent_cnt,
    input  logic [AW-1:0]            probe,
    output logic                     hit,
    output logic [IW-1:0]            hit_idx
);
    logic [DEPTH-1:0] line_eq;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign line_eq[g] = (CW'(g) < ent_cnt) &&
                            (ent_addr[g][AW-1:LINE_BITS] == probe[AW-1:LINE_BITS]);
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (line_eq[k]) begin
                hit     = 1'b1;
                hit_idx = IW'(k);
            end
        end
    end
endmodule

// File: rtl/alloc_undo_log.sv
module alloc_undo_log
    import aul_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int LINE_BITS = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          instr_valid,
    input  logic [15:0]   instr_op,
    input  logic [AW-1:0] instr_addr,
    input  logic [DW-1:0] instr_old,
    input  logic          instr_cacheable,
    output logic          busy,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          pending,
    output logic          overflow
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [CW-1:0]            cnt;
        logic                     ovf;
        logic                     wv;
        logic [AW-1:0]            wa;
        logic [DW-1:0]            wd;
    } state_t;

    state_t     st_q, st_d;
    instr_cls_e cls;
    logic       hit;
    logic [IW-1:0] hit_idx;
    logic       accept;
    logic       full;

    aul_decode u_decode (
        .op  (instr_op),
        .cls (cls)
    );

    aul_match #(
        .DEPTH     (DEPTH),
        .AW        (AW),
        .LINE_BITS (LINE_BITS),
        .CW        (CW),
        .IW        (IW)
    ) u_match (
        .ent_addr (st_q.addr),
        .ent_cnt  (st_q.cnt),
        .probe    (instr_addr),
        .hit      (hit),
        .hit_idx  (hit_idx)
    );

    assign accept = instr_valid && !st_q.wv;
    assign full   = (st_q.cnt == CW'(DEPTH));

    always_comb begin
        st_d = st_q;
        if (st_q.wv && wr_ready)
            st_d.wv = 1'b0;
        if (accept) begin
            case (cls)
                CLS_ALLOC: begin
                    if (instr_cacheable) begin
                        if (full) begin
                            st_d.ovf = 1'b1;
                        end else begin
                            st_d.addr[st_q.cnt[IW-1:0]] = instr_addr;
                            st_d.data[st_q.cnt[IW-1:0]] = instr_old;
                            st_d.cnt = st_q.cnt + CW'(1);
                        end
                    end
                end
                CLS_INVAL: begin
                    if (hit) begin
                        st_d.wv = 1'b1;
                        st_d.wa = st_q.addr[hit_idx];
                        st_d.wd = st_q.data[hit_idx];
                        for (int j = 0; j < DEPTH - 1; j++) begin
                            if (IW'(j) >= hit_idx) begin
                                st_d.addr[j] = st_q.addr[j+1];
                                st_d.data[j] = st_q.data[j+1];
                            end
                        end
                        st_d.cnt = st_q.cnt - CW'(1);
                    end
                end
                default: st_d.cnt = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= '0;
            st_q.ovf <= 1'b0;
            st_q.wv  <= 1'b0;
            st_q.wa  <= '0;
            st_q.wd  <= '0;
            st_q.addr <= '0;
            st_q.data <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.wv;
    assign wr_valid = st_q.wv;
    assign wr_addr  = st_q.wa;
    assign wr_data  = st_q.wd;
    assign pending  = (st_q.cnt != '0);
    assign overflow = st_q.ovf;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CW'(DEPTH)); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R8

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R9

    AST_OTHER_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !busy && cls == CLS_OTHER) |=> !pending); // R7

    AST_NOCACHE_KEEP: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !busy && cls == CLS_ALLOC && !instr_cacheable) |=> $stable(st_q.cnt)); // R4

    AST_MISS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !busy && cls == CLS_INVAL && !hit) |=> (!wr_valid && $stable(st_q.cnt))); // R6

    AST_HIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        hit |-> (CW'(hit_idx) < st_q.cnt)); // R5
endmodule

// File: tb/alloc_undo_log_bench.sv
`timescale 1ns/1ps
module alloc_undo_log_bench;
    localparam real CLK_NS = 20.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_op = '0;
    logic [31:0] instr_addr = '0;
    logic [31:0] instr_old = '0;
    logic        instr_cacheable = 1'b0;
    logic        wr_ready = 1'b0;
    logic        busy, wr_valid, pending, overflow;
    logic [31:0] wr_addr, wr_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] held_a, held_d;

    always #(CLK_NS / 2.0) clk = ~clk;

    alloc_undo_log u_alloc_undo_log (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_op(instr_op),
        .instr_addr(instr_addr), .instr_old(instr_old),
        .instr_cacheable(instr_cacheable), .busy(busy), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .pending(pending), .overflow(overflow)
    );

    typedef struct packed {
        logic [15:0] op;
        logic [31:0] a;
        logic [31:0] od;
        logic        c;
        logic        ew;
        logic [31:0] ea;
        logic [31:0] ed;
        logic        ep;
    } vec_t;

    // R2 R3 R4 R5 R6 R7 R10: table of single instructions and the outcome one cycle later
    localparam vec_t VEC [13] = '{
        '{16'h00C3, 32'h1000_0004, 32'h0000_0011, 1'b1, 1'b0, 32'h0, 32'h0, 1'b1},
        '{16'h00C3, 32'h1000_0010, 32'h0000_0022, 1'b1, 1'b0, 32'h0, 32'h0, 1'b1},
        '{16'h00C3, 32'h2000_0000, 32'h0000_0033, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1},
        '{16'h0093, 32'h1000_001C, 32'h0,         1'b0, 1'b1, 32'h1000_0004, 32'h0000_0011, 1'b1},
        '{16'h0093, 32'h1000_0000, 32'h0,         1'b0, 1'b1, 32'h1000_0010, 32'h0000_0022, 1'b0},
        '{16'h0093, 32'h2000_0000, 32'h0,         1'b0, 1'b0, 32'h0, 32'h0, 1'b0},
        '{16'h0FC3, 32'h3000_0040, 32'h0000_0044, 1'b1, 1'b0, 32'h0, 32'h0, 1'b1},
        '{16'h00C2, 32'h3000_0040, 32'h0,         1'b1, 1'b0, 32'h0, 32'h0, 1'b0},
        '{16'h0093, 32'h3000_0040, 32'h0,         1'b0, 1'b0, 32'h0, 32'h0, 1'b0},
        '{16'h00C3, 32'h4000_0000, 32'h0000_0055, 1'b1, 1'b0, 32'h0, 32'h0, 1'b1},
        '{16'h00C3, 32'h5000_0000, 32'h0000_0066, 1'b1, 1'b0, 32'h0, 32'h0, 1'b1},
        '{16'h0593, 32'h5000_0004, 32'h0,         1'b0, 1'b1, 32'h5000_0000, 32'h0000_0066, 1'b1},
        '{16'h0093, 32'h4000_0010, 32'h0,         1'b0, 1'b1, 32'h4000_0000, 32'h0000_0055, 1'b0}
    };

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one instruction for one edge; outputs are sampled at the following negedge
    task automatic issue(input logic [15:0] op, input logic [31:0] a, input logic [31:0] od, input logic c);
        @(negedge clk);
        instr_valid = 1'b1; instr_op = op; instr_addr = a; instr_old = od; instr_cacheable = c;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    // accept a pending restore with ready for one edge
    task automatic drain();
        if (wr_valid) begin
            wr_ready = 1'b1;
            @(negedge clk);
            wr_ready = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        chk({pending, overflow, busy, wr_valid} == 4'b0, "R1 reset outputs",
            64'({pending, overflow, busy, wr_valid}), 64'h0);

        // table walk
        for (int i = 0; i < 13; i++) begin
            issue(VEC[i].op, VEC[i].a, VEC[i].od, VEC[i].c);
            chk(wr_valid == VEC[i].ew, $sformatf("R5/R6 vec%0d wr_valid", i), 64'(wr_valid), 64'(VEC[i].ew));
            if (VEC[i].ew)
                chk({wr_addr, wr_data} == {VEC[i].ea, VEC[i].ed}, $sformatf("R5 vec%0d restore", i),
                    {wr_addr, wr_data}, {VEC[i].ea, VEC[i].ed});
            chk(pending == VEC[i].ep, $sformatf("R10 vec%0d pending", i), 64'(pending), 64'(VEC[i].ep));
            drain();
        end

        // R8: fill the log, then one store too many
        do_reset();
        for (int i = 0; i < 8; i++)
            issue(16'h00C3, 32'(i * 32), 32'(32'hA0 + i), 1'b1);
        chk(overflow == 1'b0, "R8 no overflow at exactly full", 64'(overflow), 64'h0);
        issue(16'h00C3, 32'h0000_0400, 32'h0000_00FF, 1'b1);
        chk(overflow == 1'b1, "R8 overflow set", 64'(overflow), 64'h1);
        issue(16'h0093, 32'h0000_0400, 32'h0, 1'b0);
        chk(wr_valid == 1'b0, "R8 dropped store not recorded", 64'(wr_valid), 64'h0);
        drain();
        for (int i = 0; i < 8; i++) begin
            issue(16'h0093, 32'(i * 32 + 8), 32'h0, 1'b0);
            chk(wr_valid && wr_data == 32'(32'hA0 + i) && wr_addr == 32'(i * 32),
                $sformatf("R3 order entry %0d", i), {wr_addr, wr_data}, {32'(i * 32), 32'(32'hA0 + i)});
            drain();
        end
        chk(pending == 1'b0, "R10 empty after replay", 64'(pending), 64'h0);
        issue(16'h0009, 32'h0, 32'h0, 1'b0);
        chk(overflow == 1'b1, "R8 overflow sticky across clear (R7)", 64'(overflow), 64'h1);
        do_reset();
        chk(overflow == 1'b0, "R1 reset clears overflow", 64'(overflow), 64'h0);

        // R9: stalled restore with an unrelated strobe during the stall
        issue(16'h00C3, 32'h0000_0600, 32'h0000_0071, 1'b1);
        issue(16'h00C3, 32'h0000_0604, 32'h0000_0072, 1'b1);
        issue(16'h0093, 32'h0000_0610, 32'h0, 1'b0);
        held_a = wr_addr; held_d = wr_data;
        chk(wr_valid && busy && wr_data == 32'h71, "R9 restore raised", {wr_addr, wr_data}, {32'h600, 32'h71});
        instr_valid = 1'b1; instr_op = 16'h0009; instr_addr = 32'h0; instr_cacheable = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(wr_valid && busy && wr_addr == held_a && wr_data == held_d,
                $sformatf("R9 hold cycle %0d", k), {wr_addr, wr_data}, {held_a, held_d});
        end
        wr_ready = 1'b1;
        @(negedge clk);
        wr_ready = 1'b0;
        instr_valid = 1'b0;
        chk(wr_valid == 1'b0 && busy == 1'b0, "R9 released after ready", 64'(wr_valid), 64'h0);
        chk(pending == 1'b1, "R9 strobe ignored while busy", 64'(pending), 64'h1);
        issue(16'h0093, 32'h0000_0600, 32'h0, 1'b0);
        chk(wr_valid && wr_addr == 32'h604 && wr_data == 32'h72, "R9 R5 second entry kept",
            {wr_addr, wr_data}, {32'h604, 32'h72});
        drain();

        // R7: clear with entries present, then invalidate finds nothing
        issue(16'h00C3, 32'h0000_0800, 32'h0000_0081, 1'b1);
        issue(16'h00C3, 32'h0000_0900, 32'h0000_0091, 1'b1);
        issue(16'h1234, 32'h0, 32'h0, 1'b0);
        chk(pending == 1'b0, "R7 other empties log", 64'(pending), 64'h0);
        issue(16'h0093, 32'h0000_0900, 32'h0, 1'b0);
        chk(wr_valid == 1'b0 && busy == 1'b0, "R7 R6 no restore after clear", 64'(wr_valid), 64'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule